// File: doc/BRIEF.md
# Event-Triggered Single-Cycle Transfer Engine

This block sits next to an interrupt controller and serves up to eight request lines without involving the processor's program flow. A channel is programmed with a source pointer, a destination pointer, a transfer count and a small set of mode bits. When a channel's request line goes high, the engine takes one bus cycle from the processor. In that cycle it reads one item from the source pointer and writes it to the destination pointer. The item is a byte or a 16-bit word. After the move, only one of the two pointers advances, and in normal mode the count goes down by one.

When a channel's count has run out, the engine stops moving data for that channel. Its next request is handed on as an ordinary vectored interrupt on a separate per-channel output. In continuous mode the count is never touched, so the channel keeps transferring for as long as requests arrive.

Request lines are level signals. Each request gets its answer in the same cycle: an acknowledge pulse for a transfer, or an interrupt-forward pulse for a used-up channel. The requester drops its line after the clock edge on which it saw either pulse. The memory port reads combinationally and commits the write at the clock edge that closes the stolen cycle.

Top module: `evt_xfer_engine`

## Requirements
- R1: After reset every channel's pointers, count and mode bits are zero, so the first request on any channel is forwarded as an interrupt and causes no memory write.
- R2: In any cycle at most one channel is served. The served channel is the lowest-numbered one whose request is high, and exactly one bit of `ack_o` or `irq_o` (never both) marks it in that same cycle.
- R3: A transfer drives `mem_raddr_o` with the channel's source pointer, `mem_waddr_o` with its destination pointer, and raises `mem_we_o` together with a one-hot `ack_o`. `mem_wide_o` equals the channel's word-size bit. The write data is the full read word for a word transfer, or the low read byte with the upper byte zero for a byte transfer.
- R4: After a transfer, only the pointer chosen by mode bit 1 (0 = source, 1 = destination) advances: by 1 for a byte transfer, by 2 for a word transfer. The other pointer is unchanged.
- R5: Outside continuous mode, each transfer lowers the channel's count by exactly one.
- R6: A request on a channel whose count is zero and whose continuous bit is clear produces a one-hot `irq_o` for that channel, no `ack_o`, and no memory write. The channel's pointers and count stay unchanged.
- R7: With mode bit 2 (continuous) set, transfers leave the count untouched, and a request is never forwarded, even when the count is zero.
- R8: `cfg_fld_i` selects the register written when `cfg_we_i` is high: 0 source pointer, 1 destination pointer, 2 count (low 8 data bits), 3 mode bits. The mode bits are bit 0 = word size, bit 1 = advance destination, bit 2 = continuous. A write to a register in the same cycle as a service on that channel wins over the service's update of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | 3 | Channel written |
| cfg_fld_i | input | 2 | Register selected within the channel |
| cfg_wdata_i | input | 16 | Write data |
| req_i | input | 8 | Per-channel service request levels |
| ack_o | output | 8 | One-hot: transfer done for this channel this cycle |
| irq_o | output | 8 | One-hot: request forwarded as an interrupt |
| mem_raddr_o | output | 16 | Byte read address |
| mem_rdata_i | input | 16 | Read data (byte in bits 7:0 when narrow) |
| mem_wide_o | output | 1 | Access size: 1 word, 0 byte |
| mem_we_o | output | 1 | Write enable, committed at the clock edge |
| mem_waddr_o | output | 16 | Byte write address |
| mem_wdata_o | output | 16 | Write data |

## Verification
The bench drives a channel's count down through one, to zero and then to the forwarded interrupt. A design that decrements one service too early or too late shifts the interrupt by one request. It checks continuous channels at count zero, where a design that checks the count before the mode bit would forward wrongly. It makes several channels request together, so that a wrong priority order or a double grant shows up as a swapped or missing acknowledge. It also lands register writes in the same cycle as a service on that channel, where a design that lets the service update win would lose the programmed value. Random register writes and request masks, checked against a bench model of pointers, counts and memory, cover byte and word moves with either pointer advancing.

// File: rtl/evt_xfer_pkg.sv
// Package: shared types for the event-triggered transfer engine.
// Assumes: the mode bits occupy the low three bits of a register write.
package evt_xfer_pkg;

    // Register selector inside one channel.
    typedef enum logic [1:0] {
        FLD_SRC  = 2'd0,
        FLD_DST  = 2'd1,
        FLD_CNT  = 2'd2,
        FLD_MODE = 2'd3
    } fld_e;

    // Per-channel mode bits: wide is bit 0, to_dst bit 1, cont bit 2.
    typedef struct packed {
        logic cont;
        logic to_dst;
        logic wide;
    } mode_t;

    localparam int MODE_W = 3;

endpackage

// File: rtl/evt_xfer_arb.sv
// Module: fixed-priority picker, the lowest-numbered request wins.
// Assumes: the request vector is stable around the sampling edge.
module evt_xfer_arb #(
    parameter int N_CH = 8,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] req,
    output logic [N_CH-1:0] grant,
    output logic [CHW-1:0]  idx,
    output logic            any
);

    logic [N_CH:0] lower_seen;

    assign lower_seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < N_CH; gi++) begin : g_pick
            assign lower_seen[gi+1] = lower_seen[gi] | req[gi];
            assign grant[gi]        = req[gi] & ~lower_seen[gi];
        end
    endgenerate

    assign any = lower_seen[N_CH];

    // Encodes the index of the winning channel.
    always_comb begin
        idx = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
    end

endmodule

// File: rtl/evt_xfer_chregs.sv
// Module: per-channel pointer, count and mode registers.
// Assumes: upd is one-hot or zero and only set when a transfer is legal;
// a register write takes precedence over the service update of that register.
module evt_xfer_chregs
    import evt_xfer_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int PW   = 16,
    parameter int CW   = 8,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CHW-1:0]           cfg_ch,
    input  fld_e                     cfg_fld,
    input  logic [PW-1:0]            cfg_wdata,
    input  logic [N_CH-1:0]          upd,
    output logic [N_CH-1:0][PW-1:0]  src_all,
    output logic [N_CH-1:0][PW-1:0]  dst_all,
    output logic [N_CH-1:0][CW-1:0]  cnt_all,
    output mode_t [N_CH-1:0]         mode_all
);

    genvar gc;
    generate
        for (gc = 0; gc < N_CH; gc++) begin : g_ch
            logic          hit;
            logic [PW-1:0] step;

            assign hit  = cfg_we && (cfg_ch == CHW'(gc));
            assign step = mode_all[gc].wide ? PW'(2) : PW'(1);

            // Holds one channel's state; writes win over service updates.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    src_all[gc]  <= '0;
                    dst_all[gc]  <= '0;
                    cnt_all[gc]  <= '0;
                    mode_all[gc] <= '0;
                end else begin
                    if (hit && cfg_fld == FLD_SRC)
                        src_all[gc] <= cfg_wdata;
                    else if (upd[gc] && !mode_all[gc].to_dst)
                        src_all[gc] <= src_all[gc] + step;

                    if (hit && cfg_fld == FLD_DST)
                        dst_all[gc] <= cfg_wdata;
                    else if (upd[gc] && mode_all[gc].to_dst)
                        dst_all[gc] <= dst_all[gc] + step;

                    if (hit && cfg_fld == FLD_CNT)
                        cnt_all[gc] <= cfg_wdata[CW-1:0];
                    else if (upd[gc] && !mode_all[gc].cont)
                        cnt_all[gc] <= cnt_all[gc] - CW'(1);

                    if (hit && cfg_fld == FLD_MODE)
                        mode_all[gc] <= mode_t'(cfg_wdata[MODE_W-1:0]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/evt_xfer_dp.sv
// Module: memory-port data path for one stolen cycle.
// Assumes: the memory returns a narrow read in bits 7:0 of rdata.
module evt_xfer_dp
    import evt_xfer_pkg::*;
#(
    parameter int PW = 16,
    parameter int DW = 16
) (
    input  logic [PW-1:0] sel_src,
    input  logic [PW-1:0] sel_dst,
    input  mode_t         sel_mode,
    input  logic          do_xfer,
    input  logic [DW-1:0] rdata,
    output logic [PW-1:0] raddr,
    output logic [PW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          wide,
    output logic          we
);

    // Routes addresses and strobes from the selected channel.
    always_comb begin
        raddr = sel_src;
        waddr = sel_dst;
        wide  = sel_mode.wide;
        we    = do_xfer;
    end

    // Passes a full word, or a zero-extended low byte.
    always_comb begin
        if (sel_mode.wide) wdata = rdata;
        else               wdata = {{(DW-8){1'b0}}, rdata[7:0]};
    end

endmodule

// File: rtl/evt_xfer_engine.sv
// Module: top of the event-triggered transfer engine.
// Picks the lowest requesting channel, then either moves one item through
// the memory port or forwards the request as an interrupt when its count
// is used up. Assumes requesters drop their line after seeing ack or irq.
module evt_xfer_engine
    import evt_xfer_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int PW   = 16,
    parameter int DW   = 16,
    parameter int CW   = 8,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [CHW-1:0]    cfg_ch_i,
    input  logic [1:0]        cfg_fld_i,
    input  logic [PW-1:0]     cfg_wdata_i,
    input  logic [N_CH-1:0]   req_i,
    output logic [N_CH-1:0]   ack_o,
    output logic [N_CH-1:0]   irq_o,
    output logic [PW-1:0]     mem_raddr_o,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              mem_wide_o,
    output logic              mem_we_o,
    output logic [PW-1:0]     mem_waddr_o,
    output logic [DW-1:0]     mem_wdata_o
);

    logic [N_CH-1:0]          grant;
    logic [CHW-1:0]           sel_idx;
    logic                     any_req;
    logic [N_CH-1:0][PW-1:0]  src_all;
    logic [N_CH-1:0][PW-1:0]  dst_all;
    logic [N_CH-1:0][CW-1:0]  cnt_all;
    mode_t [N_CH-1:0]         mode_all;
    logic [N_CH-1:0]          cont_vec;
    logic                     fwd;
    logic                     xfer;

    evt_xfer_arb #(.N_CH(N_CH)) u_arb (
        .req   (req_i),
        .grant (grant),
        .idx   (sel_idx),
        .any   (any_req)
    );

    evt_xfer_chregs #(.N_CH(N_CH), .PW(PW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we_i),
        .cfg_ch    (cfg_ch_i),
        .cfg_fld   (fld_e'(cfg_fld_i)),
        .cfg_wdata (cfg_wdata_i),
        .upd       (ack_o),
        .src_all   (src_all),
        .dst_all   (dst_all),
        .cnt_all   (cnt_all),
        .mode_all  (mode_all)
    );

    // Decides between a transfer and an interrupt hand-off.
    always_comb begin
        fwd   = any_req && (cnt_all[sel_idx] == '0) && !mode_all[sel_idx].cont;
        xfer  = any_req && !fwd;
        ack_o = xfer ? grant : '0;
        irq_o = fwd  ? grant : '0;
    end

    // Gathers continuous bits for the checker.
    always_comb begin
        for (int i = 0; i < N_CH; i++) cont_vec[i] = mode_all[i].cont;
    end

    evt_xfer_dp #(.PW(PW), .DW(DW)) u_dp (
        .sel_src  (src_all[sel_idx]),
        .sel_dst  (dst_all[sel_idx]),
        .sel_mode (mode_all[sel_idx]),
        .do_xfer  (xfer),
        .rdata    (mem_rdata_i),
        .raddr    (mem_raddr_o),
        .waddr    (mem_waddr_o),
        .wdata    (mem_wdata_o),
        .wide     (mem_wide_o),
        .we       (mem_we_o)
    );

endmodule

// File: rtl/evt_xfer_chk.sv
// Module: property checker for the transfer engine, bound to the top.
// Assumes: it sees the channel registers through bound connections.
module evt_xfer_chk #(
    parameter int N_CH = 8,
    parameter int PW   = 16,
    parameter int CW   = 8,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [CHW-1:0]           cfg_ch,
    input logic [N_CH-1:0]          req,
    input logic [N_CH-1:0]          ack,
    input logic [N_CH-1:0]          irq,
    input logic                     mem_we,
    input logic [N_CH-1:0][PW-1:0]  src_all,
    input logic [N_CH-1:0][PW-1:0]  dst_all,
    input logic [N_CH-1:0][CW-1:0]  cnt_all,
    input logic [N_CH-1:0]          cont_vec
);

    logic [N_CH-1:0] served;
    assign served = ack | irq;

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(served) && ((ack & irq) == '0));

    p_lowest_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (((served & req) != '0) && (((served - 1'b1) & req) == '0)));

    p_write_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(ack) == 1));

    genvar gk;
    generate
        for (gk = 0; gk < N_CH; gk++) begin : g_prop
            logic hit;
            assign hit = cfg_we && (cfg_ch == CHW'(gk));

            p_one_ptr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[gk] && !hit) |=> ($stable(src_all[gk]) != $stable(dst_all[gk])));

            p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[gk] && !cont_vec[gk] && !hit) |=>
                    (cnt_all[gk] == CW'($past(cnt_all[gk]) - CW'(1))));

            p_fwd_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                irq[gk] |-> ((cnt_all[gk] == '0) && !cont_vec[gk] && !mem_we));

            p_cont_holds_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[gk] && cont_vec[gk] && !hit) |=> $stable(cnt_all[gk]));
        end
    endgenerate

endmodule

bind evt_xfer_engine evt_xfer_chk #(.N_CH(N_CH), .PW(PW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we_i),
    .cfg_ch   (cfg_ch_i),
    .req      (req_i),
    .ack      (ack_o),
    .irq      (irq_o),
    .mem_we   (mem_we_o),
    .src_all  (src_all),
    .dst_all  (dst_all),
    .cnt_all  (cnt_all),
    .cont_vec (cont_vec)
);

// File: tb/evt_xfer_engine_tb.sv
// Bench: directed corners plus seeded random traffic against a bench model.
module evt_xfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_ch_i = '0;
    logic [1:0]  cfg_fld_i = '0;
    logic [15:0] cfg_wdata_i = '0;
    logic [7:0]  req_i = '0;
    logic [7:0]  ack_o, irq_o;
    logic [15:0] mem_raddr_o, mem_rdata_i, mem_waddr_o, mem_wdata_o;
    logic        mem_wide_o, mem_we_o;

    always #2.5 clk = ~clk;

    evt_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_fld_i(cfg_fld_i),
        .cfg_wdata_i(cfg_wdata_i), .req_i(req_i), .ack_o(ack_o), .irq_o(irq_o),
        .mem_raddr_o(mem_raddr_o), .mem_rdata_i(mem_rdata_i),
        .mem_wide_o(mem_wide_o), .mem_we_o(mem_we_o),
        .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o)
    );

    // Byte memory with combinational read and clocked write (low 8 address bits).
    logic [7:0] mem [256];
    assign mem_rdata_i = mem_wide_o ?
        {mem[mem_raddr_o[7:0] + 8'd1], mem[mem_raddr_o[7:0]]} :
        {8'h00, mem[mem_raddr_o[7:0]]};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (mem_we_o) begin
            mem[mem_waddr_o[7:0]] <= mem_wdata_o[7:0];
            if (mem_wide_o) mem[mem_waddr_o[7:0] + 8'd1] <= mem_wdata_o[15:8];
        end
    end

    // Bench model of the channel registers.
    logic [15:0] m_src [8];
    logic [15:0] m_dst [8];
    logic [7:0]  m_cnt [8];
    logic [2:0]  m_mode [8];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic bit will_fwd(input int c);
        return (m_cnt[c] == 8'd0) && !m_mode[c][2];
    endfunction

    function automatic void model_service(input int c);
        logic [15:0] st;
        st = m_mode[c][0] ? 16'd2 : 16'd1;
        if (m_mode[c][1]) m_dst[c] = m_dst[c] + st;
        else              m_src[c] = m_src[c] + st;
        if (!m_mode[c][2]) m_cnt[c] = m_cnt[c] - 8'd1;
    endfunction

    function automatic void model_write(input int c, input int f, input logic [15:0] v);
        case (f)
            0: m_src[c] = v;
            1: m_dst[c] = v;
            2: m_cnt[c] = v[7:0];
            default: m_mode[c] = v[2:0];
        endcase
    endfunction

    // Checks the combinational answer for the lowest pending channel.
    task automatic check_grant(input logic [7:0] pend, input int c,
                               output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] oh;
        oh = 8'(1 << c);
        b0 = mem[m_src[c][7:0]];
        b1 = mem[m_src[c][7:0] + 8'd1];
        if (will_fwd(c)) begin
            chk(irq_o == oh, "R6", "irq_o", irq_o, oh);
            chk(ack_o == 8'h00, "R6", "ack_o", ack_o, 0);
            chk(!mem_we_o, "R6", "mem_we_o", mem_we_o, 0);
        end else begin
            chk(ack_o == oh && irq_o == 8'h00, "R2", "ack_o", ack_o, oh);
            chk(mem_we_o, "R3", "mem_we_o", mem_we_o, 1);
            chk(mem_raddr_o == m_src[c], "R3", "mem_raddr_o", mem_raddr_o, m_src[c]);
            chk(mem_waddr_o == m_dst[c], "R4", "mem_waddr_o", mem_waddr_o, m_dst[c]);
            chk(mem_wide_o == m_mode[c][0], "R3", "mem_wide_o", mem_wide_o, m_mode[c][0]);
            if (!m_mode[c][0])
                chk(mem_wdata_o[15:8] == 8'h00, "R3", "byte wdata high", mem_wdata_o[15:8], 0);
        end
        if (pend == 8'h00) b0 = 8'h00;
    endtask

    task automatic check_written(input int c, input bit was_xfer,
                                 input logic [15:0] d, input logic [7:0] b0,
                                 input logic [7:0] b1);
        if (was_xfer) begin
            chk(mem[d[7:0]] == b0, "R3", "written low byte", mem[d[7:0]], b0);
            if (m_mode[c][0])
                chk(mem[d[7:0] + 8'd1] == b1, "R3", "written high byte",
                    mem[d[7:0] + 8'd1], b1);
        end
    endtask

    task automatic cfg(input int c, input int f, input logic [15:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_ch_i = 3'(c); cfg_fld_i = 2'(f); cfg_wdata_i = v;
        @(posedge clk); #1;
        cfg_we_i = 1'b0;
        model_write(c, f, v);
    endtask

    task automatic prog(input int c, input logic [15:0] s, input logic [15:0] d,
                        input logic [7:0] n, input logic [2:0] md);
        cfg(c, 0, s); cfg(c, 1, d); cfg(c, 2, {8'h00, n}); cfg(c, 3, {13'd0, md});
    endtask

    // Serves a request mask one channel per cycle, lowest first.
    task automatic serve(input logic [7:0] mask);
        logic [7:0] pend;
        pend = mask;
        while (pend != 8'h00) begin
            int c;
            bit x;
            logic [15:0] d;
            logic [7:0] b0, b1;
            @(negedge clk);
            req_i = pend;
            #1;
            c = lowest(pend);
            x = !will_fwd(c);
            d = m_dst[c];
            check_grant(pend, c, b0, b1);
            @(posedge clk); #1;
            check_written(c, x, d, b0, b1);
            if (x) model_service(c);
            pend[c] = 1'b0;
            req_i = pend;
        end
    endtask

    // Register write and service on the same channel in one cycle.
    task automatic collide(input int c, input int f, input logic [15:0] v);
        bit x;
        logic [15:0] d;
        logic [7:0] b0, b1;
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_ch_i = 3'(c); cfg_fld_i = 2'(f); cfg_wdata_i = v;
        req_i = 8'(1 << c);
        #1;
        x = !will_fwd(c);
        d = m_dst[c];
        check_grant(req_i, c, b0, b1);
        @(posedge clk); #1;
        cfg_we_i = 1'b0; req_i = 8'h00;
        check_written(c, x, d, b0, b1);
        if (x) model_service(c);
        model_write(c, f, v);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 8; i++) begin
            m_src[i] = '0; m_dst[i] = '0; m_cnt[i] = '0; m_mode[i] = '0;
        end
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset, then the first request is forwarded.
        chk(ack_o == 0 && irq_o == 0 && !mem_we_o, "R1", "idle after reset",
            {ack_o, irq_o}, 0);
        serve(8'h20);

        // R5, R6: byte moves with source advance, count 3 runs out.
        prog(0, 16'h0010, 16'h0080, 8'd3, 3'b000);
        repeat (4) serve(8'h01);
        // R4: word moves with destination advance, count 2.
        prog(1, 16'h0020, 16'h0090, 8'd2, 3'b011);
        repeat (3) serve(8'h02);
        // R7: continuous at count zero never forwards.
        prog(2, 16'h0040, 16'h00B0, 8'd0, 3'b101);
        repeat (5) serve(8'h04);
        prog(3, 16'h0050, 16'h00C0, 8'd2, 3'b110);
        repeat (4) serve(8'h08);
        // R2: simultaneous requests, lowest first.
        prog(4, 16'h0060, 16'h00D0, 8'd4, 3'b000);
        prog(5, 16'h0068, 16'h00D8, 8'd4, 3'b001);
        prog(0, 16'h0070, 16'h00E0, 8'd1, 3'b000);
        serve(8'hFF);
        serve(8'hF1);
        serve(8'h30);
        // R8: a write in the same cycle as a service wins.
        prog(6, 16'h0030, 16'h00A0, 8'd5, 3'b000);
        collide(6, 2, 16'h0000);
        serve(8'h40);
        prog(6, 16'h0030, 16'h00A0, 8'd5, 3'b000);
        collide(6, 0, 16'h0044);
        serve(8'h40);

        // Random register writes and request masks.
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = int'($urandom_range(0, 3));
            if (sel == 0) begin
                int c, f;
                logic [15:0] v;
                c = int'($urandom_range(0, 7));
                f = int'($urandom_range(0, 3));
                v = 16'($urandom);
                if (f == 2) v = 16'($urandom_range(0, 4));
                cfg(c, f, v);
            end else begin
                serve(8'($urandom));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule